// File: doc/BRIEF.md
# External Interrupt Input Detector

This block turns one external interrupt pin into an interrupt request for a microcontroller-style interrupt system. The pin passes through a synchronizer and is then sampled only on a periodic sample tick. A trigger-mode input selects how the request is formed. In level mode the request follows the most recent sample being low. In falling-edge mode a latched flag is set when one sample reads high and the next reads low.

The latched flag is cleared by the acknowledge of this source's vector or by a software clear write. A separate wake output tells the power controller to resume the processor. It is raised while the device sits in a low-power state with this interrupt enabled and either a request is pending or the synchronized pin is low. Wake detection uses the synchronized pin directly, so it still works when the sample tick is stopped.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is applied, and after it until the first sample, `irq_req_o` and `wake_o` are 0.
- R2: The pin reaches the sampler through a two-flop synchronizer, and samples are taken only in cycles with `sample_tick_i` high. A pin change with no tick never changes `irq_req_o`.
- R3: In level mode (`edge_mode_i` = 0), `irq_req_o` is 1 exactly when the latest sample was low. The request is not latched and drops at the first tick that samples high.
- R4: In edge mode (`edge_mode_i` = 1), a tick whose new sample is low while the previous sample was high sets the request flag. `irq_req_o` shows the flag in the cycle after that tick and keeps it until it is cleared.
- R5: In edge mode, a cycle with `vec_ack_i` or `flag_clr_i` high clears the flag. If a setting tick falls in the same cycle, the set wins.
- R6: In level mode, `vec_ack_i` and `flag_clr_i` have no effect on `irq_req_o`, and no edge flag is held.
- R7: `wake_o` is registered. It is 1 in the cycle after one in which `low_power_i` and `irq_en_i` are both 1 and either `irq_req_o` is 1 or the synchronized pin is low.
- R8: Wake via the synchronized pin level needs no sample tick.
- R9: The first tick after reset only records a baseline sample. A pin already low at reset does not set the edge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| edge_mode_i | input | 1 | Trigger mode: 0 level, 1 falling edge |
| irq_en_i | input | 1 | Interrupt enable for this source |
| sample_tick_i | input | 1 | Sample strobe, one cycle wide |
| vec_ack_i | input | 1 | Vector acknowledge for this source |
| flag_clr_i | input | 1 | Software write clearing the edge flag |
| low_power_i | input | 1 | Device is in idle or power-down |
| irq_req_o | output | 1 | Interrupt request to the priority controller |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
The pin is first driven in directed patterns:
- a low level held without ticks, which separates sampling from synchronizing;
- a single high-to-low sample pair in edge mode, against the same level in level mode;
- a clear landing in the same cycle as a new edge, which shows the priority between set and clear;
- a pin that is low through reset, which shows whether a false edge appears.

Random stretches then vary the pin with slow and fast transitions, the tick density, mode switches, acknowledges and the low-power and enable states. Each cycle is compared against a reference computed in the bench. This tells a missed edge apart from a lost clear, and a wake taken from the request apart from one taken from the raw pin.

// File: rtl/eid_pkg.sv
package eid_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  localparam logic PIN_IDLE = 1'b1;
endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign chain_d[i] = d_i;
    end else begin : g_next
      assign chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eid_sampler.sv
module eid_sampler
  import eid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lvl_i,
  output logic smp_o,
  output logic fall_o
);
  logic smp_q, smp_d;
  logic primed_q, primed_d;

  // next state: a sample is taken only on the tick; the first tick primes
  always_comb begin
    smp_d    = smp_q;
    primed_d = primed_q;
    if (tick_i) begin
      smp_d    = lvl_i;
      primed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q    <= PIN_IDLE;
      primed_q <= 1'b0;
    end else begin
      smp_q    <= smp_d;
      primed_q <= primed_d;
    end
  end

  // high sample followed by low sample, only once a baseline exists
  assign fall_o = tick_i & primed_q & smp_q & ~lvl_i;
  assign smp_o  = smp_q;
endmodule

// File: rtl/eid_req.sv
module eid_req
  import eid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode_i,
  input  logic       fall_i,
  input  logic       smp_i,
  input  logic       ack_i,
  input  logic       clr_i,
  output logic       req_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (mode_i != TRIG_FALL)   flag_d = 1'b0;
    else if (fall_i)           flag_d = 1'b1;
    else if (ack_i || clr_i)   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign req_o = (mode_i == TRIG_FALL) ? flag_q : ~smp_i;
endmodule

// File: rtl/eid_wake.sv
module eid_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_i,
  input  logic en_i,
  input  logic req_i,
  input  logic lvl_i,
  output logic wake_o
);
  logic wake_q, wake_d;

  always_comb begin
    wake_d = lp_i & en_i & (req_i | ~lvl_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import eid_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic irq_en_i,
  input  logic sample_tick_i,
  input  logic vec_ack_i,
  input  logic flag_clr_i,
  input  logic low_power_i,
  output logic irq_req_o,
  output logic wake_o
);
  logic       rst_int_n;
  logic       pin_sync;
  logic       smp;
  logic       fall;
  logic       req;
  trig_mode_e mode;

  assign mode = trig_mode_e'(edge_mode_i);

  eid_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_int_n)
  );

  eid_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(pin_i), .q_o(pin_sync)
  );

  eid_sampler u_sampler (
    .clk(clk), .rst_n(rst_int_n), .tick_i(sample_tick_i),
    .lvl_i(pin_sync), .smp_o(smp), .fall_o(fall)
  );

  eid_req u_req (
    .clk(clk), .rst_n(rst_int_n), .mode_i(mode), .fall_i(fall),
    .smp_i(smp), .ack_i(vec_ack_i), .clr_i(flag_clr_i), .req_o(req)
  );

  eid_wake u_wake (
    .clk(clk), .rst_n(rst_int_n), .lp_i(low_power_i), .en_i(irq_en_i),
    .req_i(req), .lvl_i(pin_sync), .wake_o(wake_o)
  );

  assign irq_req_o = req;
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_i,
  input logic edge_mode_i,
  input logic irq_en_i,
  input logic sample_tick_i,
  input logic vec_ack_i,
  input logic flag_clr_i,
  input logic low_power_i,
  input logic irq_req_o,
  input logic wake_o
);
  // R4: in steady edge mode the request can only rise after a tick
  a_r4_set_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && $past(edge_mode_i) && $rose(irq_req_o)) |-> $past(sample_tick_i));

  // R4: with no tick and no clear the edge flag holds
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && $past(edge_mode_i) && !$past(sample_tick_i)
      && !$past(vec_ack_i) && !$past(flag_clr_i)) |-> $stable(irq_req_o));

  // R5: a clear with no tick leaves the flag low
  a_r5_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && $past(edge_mode_i) && !$past(sample_tick_i)
      && ($past(vec_ack_i) || $past(flag_clr_i))) |-> !irq_req_o);

  // R2, R3: level request changes only after a tick
  a_r3_level_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode_i && !$past(edge_mode_i) && !$past(sample_tick_i)) |-> $stable(irq_req_o));

  // R7: wake needs low power and enable in the previous cycle
  a_r7_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(low_power_i && irq_en_i));
endmodule

bind ext_irq_detect ext_irq_detect_chk u_chk (.*);

// File: tb/ext_irq_detect_bench.sv
`timescale 1ns/1ps
module ext_irq_detect_bench;
  logic clk = 1'b0;
  logic rst_n, pin_i, edge_mode_i, irq_en_i, sample_tick_i;
  logic vec_ack_i, flag_clr_i, low_power_i;
  logic irq_req_o, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  bit m_s1, m_s2, m_smp, m_prim, m_flag, m_wake;

  always #4 clk = ~clk;

  ext_irq_detect u_ext_irq_detect (.*);

  function automatic bit f_req();
    return edge_mode_i ? m_flag : !m_smp;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 1; m_s2 = 1; m_smp = 1; m_prim = 0; m_flag = 0; m_wake = 0;
  endtask

  task automatic model_step();
    bit fall, req_now;
    req_now = f_req();
    fall = sample_tick_i && m_prim && m_smp && !m_s2;
    if (!edge_mode_i)                    m_flag = 0;
    else if (fall)                       m_flag = 1;
    else if (vec_ack_i || flag_clr_i)    m_flag = 0;
    m_wake = low_power_i && irq_en_i && (req_now || !m_s2);
    if (sample_tick_i) begin m_smp = m_s2; m_prim = 1; end
    m_s2 = m_s1;
    m_s1 = pin_i;
  endtask

  // one clock: update reference at the edge, compare at the falling edge
  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, " req"}, irq_req_o, f_req());
    chk({tag, " wake"}, wake_o, m_wake);
  endtask

  task automatic quiet();
    sample_tick_i = 0; vec_ack_i = 0; flag_clr_i = 0;
  endtask

  task automatic do_reset(logic pin_lvl);
    rst_n = 0; pin_i = pin_lvl; quiet(); low_power_i = 0; irq_en_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset req", irq_req_o, 1'b0);
    chk("R1 reset wake", wake_o, 1'b0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step("R1 post-reset");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    edge_mode_i = 0;
    do_reset(1'b1);

    // R2: low pin without tick gives no level request
    pin_i = 0;
    for (int i = 0; i < 5; i++) step("R2 no tick");
    chk("R2 still idle", irq_req_o, 1'b0);
    // R3: a tick samples low
    sample_tick_i = 1; step("R3 sample low"); quiet();
    chk("R3 level req", irq_req_o, 1'b1);
    // R6: clears ignored in level mode
    vec_ack_i = 1; flag_clr_i = 1; step("R6 clear ignored"); quiet();
    chk("R6 level req kept", irq_req_o, 1'b1);
    // R3: drops on high sample
    pin_i = 1; step("R3"); step("R3");
    sample_tick_i = 1; step("R3 sample high"); quiet();
    chk("R3 level drop", irq_req_o, 1'b0);

    // R4: falling edge in edge mode
    edge_mode_i = 1;
    sample_tick_i = 1; step("R4 base"); quiet();
    pin_i = 0; step("R4"); step("R4");
    sample_tick_i = 1; step("R4 edge"); quiet();
    chk("R4 flag set", irq_req_o, 1'b1);
    sample_tick_i = 1; step("R4 low again"); quiet();
    chk("R4 flag held", irq_req_o, 1'b1);
    // R5: software clear
    flag_clr_i = 1; step("R5 sw clear"); quiet();
    chk("R5 cleared", irq_req_o, 1'b0);
    // R5: set wins over simultaneous ack
    pin_i = 1; step("R5"); step("R5");
    sample_tick_i = 1; step("R5 high"); quiet();
    pin_i = 0; step("R5"); step("R5");
    sample_tick_i = 1; vec_ack_i = 1; step("R5 set+ack"); quiet();
    chk("R5 set wins", irq_req_o, 1'b1);
    vec_ack_i = 1; step("R5 ack"); quiet();
    chk("R5 ack clears", irq_req_o, 1'b0);

    // R7, R8: wake from low pin without ticks
    low_power_i = 1; irq_en_i = 1;
    step("R8 wake"); step("R8 wake");
    chk("R8 wake level", wake_o, 1'b1);
    irq_en_i = 0; step("R7 disabled");
    chk("R7 wake off", wake_o, 1'b0);
    pin_i = 1; irq_en_i = 1;
    for (int i = 0; i < 3; i++) step("R7 idle pin");
    chk("R7 wake idle", wake_o, 1'b0);
    low_power_i = 0;

    // R9: pin already low through reset
    edge_mode_i = 1;
    do_reset(1'b0);
    edge_mode_i = 1;
    for (int i = 0; i < 3; i++) begin
      sample_tick_i = 1; step("R9 no false edge"); quiet();
    end
    chk("R9 no flag", irq_req_o, 1'b0);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(0, 9) == 0) pin_i = ~pin_i;
      if ($urandom_range(0, 199) == 0) edge_mode_i = ~edge_mode_i;
      if ($urandom_range(0, 49) == 0) low_power_i = ~low_power_i;
      if ($urandom_range(0, 49) == 0) irq_en_i = ~irq_en_i;
      sample_tick_i = ($urandom_range(0, 2) == 0);
      vec_ack_i     = ($urandom_range(0, 15) == 0);
      flag_clr_i    = ($urandom_range(0, 23) == 0);
      step(edge_mode_i ? "R4 R5 R7 random" : "R3 R6 R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule